// File: doc/BRIEF.md
# Packed Byte Absolute-Difference Summer

This block serves motion-estimation kernels that compare a block of reference pixels with a candidate block. Each call takes two packed operands. Every byte lane is read as an unsigned 8-bit value, and the block takes the magnitude of the difference between the two bytes in each lane. It then adds these magnitudes into one total. The total is placed in the low 16-bit word of a 64-bit result word, and every bit above that word is cleared.

Operands enter on a valid/ready handshake and pass through a three-stage pipeline: lane differences, pair sums, then the final total. A new operand pair can be taken on every cycle. When the consumer holds off, the finished result stays on the output, and the input side refuses new work until the output drains. A per-call wide flag makes the upper 64-bit half of each operand a second, independent group of lanes. That group produces its own zero-extended total in the low word of the upper result half. In narrow calls the upper operand bytes are ignored and the upper result half reads zero. Totals are not carried from one call to the next.

Top module: `sad_unit`

## Requirements
- R1: Each lane contributes |a - b| with both bytes read as unsigned values (0..255), so swapping the two operands never changes a total.
- R2: Bits [15:0] of the lower result half carry the sum of the eight lane magnitudes taken from operand bits [63:0].
- R3: In each 64-bit result half, bits 16 to 63 of that half are zero whenever out_valid is high.
- R4: With in_wide low at acceptance, result bits [127:64] are zero and operand bits [127:64] have no effect on the result.
- R5: With in_wide high at acceptance, result bits [79:64] carry the total for operand bits [127:64], independent of the lower half.
- R6: A pair accepted at a rising edge (in_valid and in_ready both high) appears on out_valid after the third rising edge when out_ready stays high. Back-to-back pairs are accepted every cycle, and results leave in acceptance order with none lost.
- R7: While out_valid is high and out_ready is low, out_valid stays high and result stays unchanged on the next cycle.
- R8: in_ready is low exactly when out_valid is high and out_ready is low.
- R9: After synchronous reset, out_valid is low, in_ready is high and result is all zero.
- R10: The largest total, eight lanes of 255 against 0, yields 2040 (0x7F8) in a half without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Pipeline can take an operand pair this cycle |
| in_wide | input | 1 | 1: both 64-bit halves active; 0: lower half only |
| op_a | input | 128 | First packed operand, byte lanes |
| op_b | input | 128 | Second packed operand, byte lanes |
| out_valid | output | 1 | Result word available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 128 | Per-half totals, zero-extended from bit 0 of each half |

## Verification
The bench builds the block with its default parameters: eight lanes of eight bits per half, two halves and a 16-bit sum word. With these values the full 2040 total is reachable, and the 11-bit sum leaves bits 11 to 15 zero, so a wrapped or truncated total shows up as a mismatch. Because both halves are present, narrow and wide calls can be mixed cycle by cycle. The bench can then show that a narrow call leaves no trace of the upper operand bytes, even when the call sits next to wide calls in the pipeline. Random back-pressure on out_ready exercises stalls in every stage.

// File: rtl/sad_pkg.sv
`timescale 1ns/1ps
package sad_pkg;

    localparam int DEF_LANE_W = 8;
    localparam int DEF_LANES  = 8;
    localparam int DEF_HALVES = 2;
    localparam int DEF_WORD_W = 16;
    localparam int PIPE_DEPTH = 3;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } width_mode_e;

    // Bits needed to hold lanes * (2**lane_w - 1) without wrap.
    function automatic int total_width(input int lanes, input int lane_w);
        int top_val;
        int bits;
        top_val = lanes * ((1 << lane_w) - 1);
        bits = 0;
        while ((1 << bits) <= top_val) bits++;
        return bits;
    endfunction

    function automatic int max_total(input int lanes, input int lane_w);
        return lanes * ((1 << lane_w) - 1);
    endfunction

endpackage

// File: rtl/sad_lane_absdiff.sv
`timescale 1ns/1ps
module sad_lane_absdiff #(
    parameter int LANE_W = 8
) (
    input  logic              lane_en,
    input  logic [LANE_W-1:0] x,
    input  logic [LANE_W-1:0] y,
    output logic [LANE_W-1:0] mag
);
    always_comb begin
        if (!lane_en)
            mag = '0;
        else if (x >= y)
            mag = x - y;
        else
            mag = y - x;
    end
endmodule

// File: rtl/sad_pipe_ctrl.sv
`timescale 1ns/1ps
module sad_pipe_ctrl #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic out_ready,
    output logic advance,
    output logic out_valid
);
    logic [STAGES-1:0] occ_q;

    // Whole pipe moves together; it only freezes when the last stage
    // holds a result the consumer has not taken.
    assign advance   = !occ_q[STAGES-1] || out_ready;
    assign out_valid = occ_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst)
            occ_q <= '0;
        else if (advance)
            occ_q <= {occ_q[STAGES-2:0], in_valid};
    end
endmodule

// File: rtl/sad_half_path.sv
`timescale 1ns/1ps
module sad_half_path #(
    parameter int LANE_W = 8,
    parameter int LANES  = 8,
    parameter int WORD_W = 16,
    localparam int HALF_W = LANE_W * LANES,
    localparam int PAIRS  = LANES / 2,
    localparam int PAIR_W = LANE_W + 1,
    localparam int SUM_W  = sad_pkg::total_width(LANES, LANE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              half_en,
    input  logic [HALF_W-1:0] src_x,
    input  logic [HALF_W-1:0] src_y,
    output logic [HALF_W-1:0] word_out
);
    logic [LANES-1:0][LANE_W-1:0] mag_d, mag_q;
    logic [PAIRS-1:0][PAIR_W-1:0] pair_d, pair_q;
    logic [SUM_W-1:0]             total_d;
    logic [HALF_W-1:0]            word_q;

    // Stage 1: per-lane magnitude
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sad_lane_absdiff #(.LANE_W(LANE_W)) u_lane (
            .lane_en (half_en),
            .x       (src_x[l*LANE_W +: LANE_W]),
            .y       (src_y[l*LANE_W +: LANE_W]),
            .mag     (mag_d[l])
        );
    end

    // Stage 2: neighbouring lanes added in pairs
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_d[p] = PAIR_W'(mag_q[2*p]) + PAIR_W'(mag_q[2*p+1]);
    end

    // Stage 3: pair sums folded into one total
    always_comb begin
        total_d = '0;
        for (int p = 0; p < PAIRS; p++)
            total_d = total_d + SUM_W'(pair_q[p]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_q  <= '0;
            pair_q <= '0;
            word_q <= '0;
        end else if (advance) begin
            mag_q  <= mag_d;
            pair_q <= pair_d;
            word_q <= HALF_W'(total_d);
        end
    end

    assign word_out = word_q;
endmodule

// File: rtl/sad_unit.sv
`timescale 1ns/1ps
module sad_unit #(
    parameter int LANE_W = sad_pkg::DEF_LANE_W,
    parameter int LANES  = sad_pkg::DEF_LANES,
    parameter int HALVES = sad_pkg::DEF_HALVES,
    parameter int WORD_W = sad_pkg::DEF_WORD_W,
    localparam int HALF_W = LANE_W * LANES,
    localparam int DATA_W = HALF_W * HALVES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] result
);
    import sad_pkg::*;

    logic        advance;
    width_mode_e mode;

    assign mode = width_mode_e'(in_wide);

    sad_pipe_ctrl #(.STAGES(PIPE_DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .advance   (advance),
        .out_valid (out_valid)
    );

    assign in_ready = advance;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic en;
        if (h == 0) begin : g_base
            assign en = 1'b1;
        end else begin : g_ext
            assign en = (mode == MODE_WIDE);
        end

        sad_half_path #(
            .LANE_W (LANE_W),
            .LANES  (LANES),
            .WORD_W (WORD_W)
        ) u_path (
            .clk      (clk),
            .rst      (rst),
            .advance  (advance),
            .half_en  (en),
            .src_x    (op_a[h*HALF_W +: HALF_W]),
            .src_y    (op_b[h*HALF_W +: HALF_W]),
            .word_out (result[h*HALF_W +: HALF_W])
        );
    end
endmodule

// File: rtl/sad_unit_checker.sv
`timescale 1ns/1ps
module sad_unit_checker #(
    parameter int LANE_W = 8,
    parameter int LANES  = 8,
    parameter int HALVES = 2,
    parameter int WORD_W = 16,
    localparam int HALF_W = LANE_W * LANES,
    localparam int DATA_W = HALF_W * HALVES,
    localparam int TOP_V  = sad_pkg::max_total(LANES, LANE_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] result
);
    a_r7_valid_held: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid);

    a_r7_data_held: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(result));

    a_r8_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    a_r8_empty_accepts: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    for (genvar h = 0; h < HALVES; h++) begin : g_chk
        a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (result[h*HALF_W+WORD_W +: HALF_W-WORD_W] == '0));

        a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (int'(result[h*HALF_W +: WORD_W]) <= TOP_V));
    end
endmodule

bind sad_unit sad_unit_checker #(
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .HALVES (HALVES),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .result    (result)
);

// File: tb/sad_unit_test.sv
`timescale 1ns/1ps
module sad_unit_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_wide = 1'b0;
    logic [127:0] op_a = '0;
    logic [127:0] op_b = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;

    logic [127:0] exp_q[$];
    string        tag_q[$];
    logic         was_stalled = 1'b0;
    logic [127:0] held_res = '0;

    always #10 clk = ~clk;

    sad_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_wide(in_wide), .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
        .out_ready(out_ready), .result(result)
    );

    function automatic logic [127:0] model(input logic [127:0] a,
                                           input logic [127:0] b,
                                           input logic w);
        logic [127:0] r = '0;
        for (int h = 0; h < 2; h++) begin
            int s = 0;
            if (h == 1 && !w) continue;
            for (int i = 0; i < 8; i++) begin
                int x = int'(a[h*64 + i*8 +: 8]);
                int y = int'(b[h*64 + i*8 +: 8]);
                s += (x > y) ? x - y : y - x;
            end
            r[h*64 +: 16] = 16'(s);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at falling edge, then judge the handshakes for the coming rising edge.
    task automatic cycle(input logic v, input logic w, input logic [127:0] a,
                         input logic [127:0] b, input logic r, input string tag);
        @(negedge clk);
        in_valid = v; in_wide = w; op_a = a; op_b = b; out_ready = r;
        #1;
        check(in_ready == !(out_valid && !out_ready), "R8",
              128'(in_ready), 128'(!(out_valid && !out_ready)));
        if (was_stalled)
            check(out_valid && result == held_res, "R7", result, held_res);
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0)
                check(1'b0, "R6 unexpected output", result, '0);
            else begin
                logic [127:0] e = exp_q.pop_front();
                string t = tag_q.pop_front();
                check(result == e, t, result, e);
            end
        end
        if (in_valid && in_ready) begin
            exp_q.push_back(model(a, b, w));
            tag_q.push_back(tag);
        end
        was_stalled = out_valid && !out_ready;
        held_res = result;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5AD1));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        check(!out_valid, "R9 out_valid", 128'(out_valid), 0);
        check(in_ready, "R9 in_ready", 128'(in_ready), 1);
        check(result == '0, "R9 result", result, '0);

        // R6 latency: accepted at next edge, valid after the third edge
        cycle(1, 1, {64'h0, 64'h0102030405060708}, {64'h0, 64'h0807060504030201}, 1, "R1 R2 latency");
        cycle(0, 0, '0, '0, 1, "idle");
        check(!out_valid, "R6 one edge", 128'(out_valid), 0);
        cycle(0, 0, '0, '0, 1, "idle");
        check(!out_valid, "R6 two edges", 128'(out_valid), 0);
        cycle(0, 0, '0, '0, 1, "idle");
        check(out_valid, "R6 three edges", 128'(out_valid), 1);

        // R1 operand order swap, R10 maxima, R4 ignored upper bytes, R5 wide
        cycle(1, 0, 128'h10, 128'hF0, 1, "R1 a<b");
        cycle(1, 0, 128'hF0, 128'h10, 1, "R1 a>b");
        cycle(1, 1, {2{64'hFFFF_FFFF_FFFF_FFFF}}, '0, 1, "R10 max both halves");
        cycle(1, 1, '0, {2{64'hFFFF_FFFF_FFFF_FFFF}}, 1, "R10 max swapped");
        cycle(1, 0, {64'hDEAD_BEEF_1234_5678, 64'h55}, {64'h0BAD_F00D_CAFE_0001, 64'h50}, 1, "R4 narrow upper ignored");
        cycle(1, 1, {64'h00FF_00FF_00FF_00FF, 64'h1}, {64'hFF00_FF00_FF00_FF00, 64'h2}, 1, "R5 wide halves");
        cycle(1, 0, {2{64'hFFFF_FFFF_FFFF_FFFF}}, '0, 1, "R3 R4 narrow max");
        repeat (4) cycle(0, 0, '0, '0, 1, "idle");
        check(exp_q.size() == 0, "R6 directed drained", 128'(exp_q.size()), 0);

        // R6 throughput: back-to-back with no back-pressure
        for (int k = 0; k < 8; k++) begin
            cycle(1, k[0], rnd128(), rnd128(), 1, "R6 back-to-back");
            check(in_ready, "R6 in_ready every cycle", 128'(in_ready), 1);
        end

        // R7 stall: hold consumer off for several cycles
        cycle(1, 1, rnd128(), rnd128(), 0, "R7 stall");
        repeat (5) cycle(1, 1, rnd128(), rnd128(), 0, "R7 stall");
        repeat (6) cycle(0, 0, '0, '0, 1, "idle");

        // Random mix of modes, operands and back-pressure
        for (int k = 0; k < 4000; k++) begin
            logic [127:0] a = rnd128();
            logic [127:0] b = rnd128();
            int sel = $urandom_range(0, 9);
            if (sel == 0) a = {128{1'b1}};
            if (sel == 1) b = '0;
            if (sel == 2) b = a;
            cycle(($urandom_range(0, 3) != 0), $urandom_range(0, 1),
                  a, b, ($urandom_range(0, 9) < 7), "R2 R4 R5 random");
        end
        repeat (10) cycle(0, 0, '0, '0, 1, "idle");
        check(exp_q.size() == 0, "R6 all results delivered", 128'(exp_q.size()), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule